// File: doc/BRIEF.md
# 8-bit Arithmetic and Flag Unit

This block is the arithmetic core of a small 8-bit accumulator processor. Each cycle in which a valid strobe is raised, it takes an operation code, the accumulator value, a second data operand and its own stored carry flag. It produces a registered result and updates four held status flags: negative, zero, carry and overflow. The operations are add with carry, subtract with borrow, increment, decrement, and the flag side of register loads and stores. Arithmetic is always binary. There is no decimal adjustment.

The operand for increment, decrement and load is whatever the decoder routes to the second data input. That input can be a register or a byte read from memory. Subtraction treats the carry as an inverted borrow, so a set carry means no borrow is pending. Each class of operation has its own rule for which flags it writes. Every other flag keeps its previous value.

Top module: `alu8_flag_unit`

## Requirements
- R1: Op code 0 (add with carry) gives result = acc + opnd + C, truncated to 8 bits. C becomes bit 8 of the 9-bit sum.
- R2: Op code 1 (subtract with borrow) gives result = acc - opnd - (1 - C), truncated to 8 bits. C becomes 1 when no borrow leaves bit 7, and 0 otherwise.
- R3: After op codes 0 and 1, V is set when the two adder inputs share a sign bit and the result's sign bit differs from it. For subtract, the adder inputs are acc and the one's complement of opnd.
- R4: After op codes 0 and 1, N equals result bit 7, and Z is 1 exactly when all 8 result bits are zero.
- R5: Op code 2 (increment) gives opnd + 1 and op code 3 (decrement) gives opnd - 1, both wrapping modulo 256. N and Z follow the result, and C and V keep their previous values.
- R6: Op code 4 (load) returns opnd as the result and sets N and Z from it. C and V are unchanged.
- R7: Op code 5 (store) returns acc as the result and changes no flag.
- R8: out_valid is high exactly in the cycle after a cycle in which in_valid was high. While in_valid is low, the result and all flags hold.
- R9: A synchronous active-high reset clears the result, out_valid and all four flags.
- R10: Arithmetic is purely binary. For example, 0x09 + 0x01 with C clear gives 0x0A.
- R11: Op codes 6 and 7 are reserved. They leave the result and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Operation code (0 add, 1 subtract, 2 increment, 3 decrement, 4 load, 5 store, 6 and 7 reserved) |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand (register or memory byte) |
| result | output | 8 | Registered result |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag (inverted borrow after subtract) |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The bench chains operations so that each carry produced feeds the next add or subtract. A unit that used the carry with the wrong polarity in subtract would therefore show off-by-one differences. Signed overflow is driven in both directions for add and for subtract. A design that judged subtract overflow from the raw operand sign, instead of its complement, would report the wrong V on 0x80 - 0x01 and on 0x7F - 0x80. Increment and decrement are run across the 0x7F/0x80 and 0x00/0xFF wrap points while C and V are set, so that a design writing all four flags would visibly clear them. Store, idle cycles and the reserved codes are checked for leaving earlier results and flags untouched.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADC   = 3'd0,
    OP_SBC   = 3'd1,
    OP_INC   = 3'd2,
    OP_DEC   = 3'd3,
    OP_LOAD  = 3'd4,
    OP_STORE = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/alu8_operand_mux.sv
module alu8_operand_mux
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  input  logic         carry,
  output logic [W-1:0] add_a,
  output logic [W-1:0] add_b,
  output logic         add_cin
);
  // Every arithmetic op is mapped onto a single adder.
  always_comb begin
    unique case (op)
      OP_ADC: begin
        add_a = acc;  add_b = opnd;         add_cin = carry;
      end
      OP_SBC: begin
        add_a = acc;  add_b = ~opnd;        add_cin = carry;
      end
      OP_INC: begin
        add_a = opnd; add_b = '0;           add_cin = 1'b1;
      end
      OP_DEC: begin
        add_a = opnd; add_b = {W{1'b1}};    add_cin = 1'b0;
      end
      default: begin
        add_a = acc;  add_b = opnd;         add_cin = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] carry;

  assign carry[0] = cin;

  // Ripple chain, one full adder per bit.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = a[i] ^ b[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
  end

  assign cout = carry[W];
  // Same-signed inputs whose sum changes sign.
  assign ovf  = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/alu8_flag_next.sv
module alu8_flag_next
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  input  logic [W-1:0] sum,
  input  logic         cout,
  input  logic         ovf,
  input  logic [W-1:0] old_res,
  input  flags_t       old_flags,
  output logic [W-1:0] nxt_res,
  output flags_t       nxt_flags
);
  always_comb begin
    nxt_res   = old_res;
    nxt_flags = old_flags;
    unique case (op)
      OP_ADC, OP_SBC: begin
        nxt_res   = sum;
        nxt_flags = '{n: sum[W-1], z: (sum == '0), c: cout, v: ovf};
      end
      OP_INC, OP_DEC: begin
        nxt_res     = sum;
        nxt_flags.n = sum[W-1];
        nxt_flags.z = (sum == '0);
      end
      OP_LOAD: begin
        nxt_res     = opnd;
        nxt_flags.n = opnd[W-1];
        nxt_flags.z = (opnd == '0);
      end
      OP_STORE: begin
        nxt_res = acc;
      end
      default: begin
        nxt_res   = old_res;
        nxt_flags = old_flags;
      end
    endcase
  end
endmodule

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  op,
  input  logic [W-1:0]     acc_in,
  input  logic [W-1:0]     opnd_in,
  output logic [W-1:0]     result,
  output logic             out_valid,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);
  alu_op_e      op_e;
  flags_t       flags_q, flags_d;
  logic [W-1:0] res_q, res_d;
  logic [W-1:0] add_a, add_b, sum;
  logic         add_cin, cout, ovf;
  logic         vld_q;

  assign op_e = alu_op_e'(op);

  alu8_operand_mux #(.W(W)) i_mux (
    .op(op_e), .acc(acc_in), .opnd(opnd_in), .carry(flags_q.c),
    .add_a(add_a), .add_b(add_b), .add_cin(add_cin)
  );

  alu8_adder #(.W(W)) i_add (
    .a(add_a), .b(add_b), .cin(add_cin),
    .sum(sum), .cout(cout), .ovf(ovf)
  );

  alu8_flag_next #(.W(W)) i_flags (
    .op(op_e), .acc(acc_in), .opnd(opnd_in), .sum(sum), .cout(cout),
    .ovf(ovf), .old_res(res_q), .old_flags(flags_q),
    .nxt_res(res_d), .nxt_flags(flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      flags_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q   <= res_d;
        flags_q <= flags_d;
      end
    end
  end

  assign result    = res_q;
  assign out_valid = vld_q;
  assign flag_n    = flags_q.n;
  assign flag_z    = flags_q.z;
  assign flag_c    = flags_q.c;
  assign flag_v    = flags_q.v;
endmodule

// File: rtl/alu8_flag_unit_checker.sv
module alu8_flag_unit_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [2:0]   op,
  input logic [W-1:0] acc_in,
  input logic [W-1:0] opnd_in,
  input logic [W-1:0] result,
  input logic         out_valid,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_c,
  input logic         flag_v
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R9: state is cleared after a reset edge
  always @(negedge clk) begin
    if (rst_q)
      assert_reset_clear_R9: assert (result == '0 && !out_valid &&
                                     !flag_n && !flag_z && !flag_c && !flag_v)
        else $error("reset did not clear state");
  end

  // R1: add with carry
  assert_adc_sum_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd0) |=>
      ({flag_c, result} == ({1'b0, $past(acc_in)} + {1'b0, $past(opnd_in)}
                            + {{W{1'b0}}, $past(flag_c)})));

  // R2: subtract with inverted borrow
  assert_sbc_diff_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd1) |=>
      (result == $past(acc_in) - $past(opnd_in) - {{(W-1){1'b0}}, !$past(flag_c)}));

  // R5, R6: increment, decrement and load keep C and V
  assert_keep_cv_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 3'd2 || op == 3'd3 || op == 3'd4)) |=>
      ($stable(flag_c) && $stable(flag_v)));

  // R4, R6: N and Z track the result after a load
  assert_load_nz_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd4) |=>
      (flag_n == result[W-1] && flag_z == (result == '0)));

  // R7: store changes no flag
  assert_store_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd5) |=>
      $stable({flag_n, flag_z, flag_c, flag_v}));

  // R8: valid strobe timing
  assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R8: idle cycles hold state
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) &&
                   $stable({flag_n, flag_z, flag_c, flag_v})));

  // R11: reserved codes hold state
  assert_reserved_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[2:1] == 2'b11) |=>
      ($stable(result) && $stable({flag_n, flag_z, flag_c, flag_v})));
endmodule

bind alu8_flag_unit alu8_flag_unit_checker #(.W(W)) i_alu8_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
  .acc_in(acc_in), .opnd_in(opnd_in), .result(result),
  .out_valid(out_valid), .flag_n(flag_n), .flag_z(flag_z),
  .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/test_alu8_flag_unit.sv
module test_alu8_flag_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [2:0] op = 3'd0;
  logic [7:0] acc_in = 8'h00;
  logic [7:0] opnd_in = 8'h00;
  logic [7:0] result;
  logic       out_valid, flag_n, flag_z, flag_c, flag_v;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu8_flag_unit i_alu8_flag_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .acc_in(acc_in), .opnd_in(opnd_in), .result(result),
    .out_valid(out_valid), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v)
  );

  // {op, acc, opnd, expected result, expected NZCV}; entries run in order
  // so the carry of each one feeds the next.
  localparam int NV = 20;
  localparam logic [30:0] VEC [NV] = '{
    {3'd0, 8'h50, 8'h10, 8'h60, 4'b0000},  // R1 plain add
    {3'd0, 8'h50, 8'h50, 8'hA0, 4'b1001},  // R3 positive overflow
    {3'd0, 8'hFF, 8'h01, 8'h00, 4'b0110},  // R1 carry out, R4 zero
    {3'd0, 8'h10, 8'h20, 8'h31, 4'b0000},  // R1 carry in used
    {3'd1, 8'h05, 8'h03, 8'h01, 4'b0010},  // R2 borrow pending
    {3'd1, 8'h05, 8'h05, 8'h00, 4'b0110},  // R2 no borrow, zero
    {3'd1, 8'h03, 8'h05, 8'hFE, 4'b1000},  // R2 borrow out
    {3'd1, 8'h80, 8'h01, 8'h7E, 4'b0011},  // R3 subtract overflow
    {3'd2, 8'h00, 8'h7F, 8'h80, 4'b1011},  // R5 inc keeps C,V
    {3'd3, 8'h00, 8'h01, 8'h00, 4'b0111},  // R5 dec to zero
    {3'd2, 8'h00, 8'hFF, 8'h00, 4'b0111},  // R5 inc wrap
    {3'd3, 8'h00, 8'h00, 8'hFF, 4'b1011},  // R5 dec wrap
    {3'd4, 8'h00, 8'h00, 8'h00, 4'b0111},  // R6 load zero
    {3'd5, 8'h9C, 8'h00, 8'h9C, 4'b0111},  // R7 store no flags
    {3'd4, 8'h00, 8'hC3, 8'hC3, 4'b1011},  // R6 load negative
    {3'd0, 8'h09, 8'h01, 8'h0B, 4'b0000},  // R10 binary add with carry
    {3'd0, 8'h09, 8'h01, 8'h0A, 4'b0000},  // R10 binary add
    {3'd6, 8'h11, 8'h22, 8'h0A, 4'b0000},  // R11 reserved holds
    {3'd1, 8'h7F, 8'h80, 8'hFE, 4'b1001},  // R3 subtract overflow, negative
    {3'd0, 8'h80, 8'h80, 8'h00, 4'b0111}   // R3 negative overflow
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; op = o; acc_in = a; opnd_in = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check("R9 reset result", result, 8'h00);
    check("R9 reset flags", {4'b0, flag_n, flag_z, flag_c, flag_v}, 8'h00);
    check("R9 reset valid", {7'b0, out_valid}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][30:28], VEC[i][27:20], VEC[i][19:12]);
      check($sformatf("vec %0d result (R1-R7 table)", i), result, VEC[i][11:4]);
      check($sformatf("vec %0d flags", i), {4'b0, flag_n, flag_z, flag_c, flag_v},
            {4'b0, VEC[i][3:0]});
      check($sformatf("vec %0d R8 out_valid", i), {7'b0, out_valid}, 8'h01);
    end

    // R8: idle cycle with changed inputs holds everything
    @(negedge clk);
    op = 3'd0; acc_in = 8'h01; opnd_in = 8'h01;
    @(negedge clk);
    check("R8 idle result", result, 8'h00);
    check("R8 idle flags", {4'b0, flag_n, flag_z, flag_c, flag_v}, 8'h07);
    check("R8 idle valid", {7'b0, out_valid}, 8'h00);

    // R11: code 7 holds too
    apply(3'd7, 8'h55, 8'h55);
    check("R11 code7 result", result, 8'h00);
    check("R11 code7 flags", {4'b0, flag_n, flag_z, flag_c, flag_v}, 8'h07);

    // R2: subtract with carry set after reset-free chain: 0x00 - 0x01 = 0xFF borrow
    apply(3'd1, 8'h00, 8'h01);
    check("R2 zero minus one", result, 8'hFF);
    check("R2 zero minus one flags", {4'b0, flag_n, flag_z, flag_c, flag_v}, 8'h08);

    // R9: reset in the middle of operation
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; op = 3'd4; opnd_in = 8'hAA;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    check("R9 mid reset result", result, 8'h00);
    check("R9 mid reset flags", {4'b0, flag_n, flag_z, flag_c, flag_v}, 8'h00);

    // R1 after reset: carry is clear
    apply(3'd0, 8'h01, 8'h01);
    check("R1 post reset add", result, 8'h02);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule